// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Direct Routing

This block gathers 32 level-sensitive interrupt sources behind a small register window and presents them to a primary interrupt controller in two ways. The first is a single combined request: the raw source levels, gated by a per-source enable mask, are OR-reduced onto one line. The second is a set of direct lines. A separate routing-enable register lets each source in a fixed window (bits 21 to 30 by default) drive its own line on the primary controller. Each direct line copies the raw level whatever the mask holds.

Software reaches the block through a plain memory-mapped bus with single-cycle accesses. The register index is the byte offset within a 4 KB window shifted right by two. A read returns data in the same cycle. A write takes effect at the clock edge. All outputs are registered, so they reflect an input change or a register write one clock later. The bus has no back-pressure: every access completes in the cycle it is presented.

Top module: `sic_route_top`

## Requirements
- R1: After reset the enable mask and the routing-enable register are zero, `irq_o` is low and `route_o` is all zero.
- R2: The source vector `src_i` is sampled at every clock. A read of register index 1 (byte offset 0x04) returns the sampled vector.
- R3: A read of index 0 returns the sampled sources ANDed with the enable mask. A read of index 2 (0x08) returns the enable mask.
- R4: A write to index 2 ORs the written value into the enable mask.
- R5: A write to index 3 (0x0C) clears every mask bit that is set in the written value.
- R6: One clock after any source change or register write, `irq_o` is high exactly when the sampled sources ANDed with the mask are nonzero.
- R7: A write to index 8 (0x20) ORs only bits 21..30 of the value (the constant 0x7FE00000) into the routing-enable register. A write to index 9 (0x24) clears the bits set in the value. A read of index 8 returns the routing-enable register.
- R8: One clock after a change, `route_o[i]` equals sampled source i when routing-enable bit i is set. Otherwise it is low, and every bit outside 21..30 is always low. The mask has no effect on `route_o`.
- R9: A read of index 4 (0x10) returns sampled source bit 0 in bit 0 and zeros above it. A nonzero write to index 4 sets mask bit 0. A nonzero write to index 5 (0x14) clears mask bit 0. A zero write to either leaves the mask unchanged.
- R10: Reads of any other index, including 3, 5 and 9, return zero. Writes to any other index change no state. Byte address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read |
| src_i | input | 32 | Level-sensitive interrupt sources |
| irq_o | output | 1 | Combined masked request |
| route_o | output | 32 | Direct per-source lines (only bits 21..30 can be active) |

## Verification
The hardest case to reach is a source that toggles while its mask bit is clear and its routing bit changes at the same moment. In that case the direct line must follow the source, and the combined line must stay quiet. The random phase changes the sources every cycle and biases writes toward the routing set and clear registers and the mask clear register. This produces many such coincidences. Directed steps then fix one case exactly: mask zero, routing enabled on bit 25, and source 25 high.

// File: rtl/sic_pkg.sv
package sic_pkg;
  typedef enum logic [3:0] {
    IDX_STATUS   = 4'd0,
    IDX_RAW      = 4'd1,
    IDX_EN_SET   = 4'd2,
    IDX_EN_CLR   = 4'd3,
    IDX_SOFT_SET = 4'd4,
    IDX_SOFT_CLR = 4'd5,
    IDX_RT_SET   = 4'd8,
    IDX_RT_CLR   = 4'd9
  } reg_idx_e;
endpackage

// File: rtl/sic_regfile.sv
module sic_regfile #(
  parameter int NSRC  = 32,
  parameter int IDXW  = 10,
  parameter int RT_LO = 21,
  parameter int RT_HI = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [IDXW-1:0] idx,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] raw_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] mask_nx,
  output logic [NSRC-1:0] rt_q,
  output logic [NSRC-1:0] rt_nx,
  output logic [NSRC-1:0] rdata
);
  import sic_pkg::*;

  localparam int RT_W = RT_HI - RT_LO + 1;
  localparam logic [NSRC-1:0] RT_WIN = ({NSRC{1'b1}} >> (NSRC - RT_W)) << RT_LO;

  logic     low_hit;
  reg_idx_e sel_idx;

  assign low_hit = (idx[IDXW-1:4] == '0);
  assign sel_idx = reg_idx_e'(idx[3:0]);

  always_comb begin
    mask_nx = mask_q;
    rt_nx   = rt_q;
    if (wr_en && low_hit) begin
      case (sel_idx)
        IDX_EN_SET:   mask_nx = mask_q | wdata;
        IDX_EN_CLR:   mask_nx = mask_q & ~wdata;
        IDX_SOFT_SET: if (|wdata) mask_nx[0] = 1'b1;
        IDX_SOFT_CLR: if (|wdata) mask_nx[0] = 1'b0;
        IDX_RT_SET:   rt_nx = rt_q | (wdata & RT_WIN);
        IDX_RT_CLR:   rt_nx = rt_q & ~wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      rt_q   <= '0;
    end else begin
      mask_q <= mask_nx;
      rt_q   <= rt_nx;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && low_hit) begin
      case (sel_idx)
        IDX_STATUS:   rdata = raw_q & mask_q;
        IDX_RAW:      rdata = raw_q;
        IDX_EN_SET:   rdata = mask_q;
        IDX_SOFT_SET: rdata = {{(NSRC-1){1'b0}}, raw_q[0]};
        IDX_RT_SET:   rdata = rt_q;
        default:      rdata = '0;
      endcase
    end
  end

  AST_EN_SET_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDXW'(2)) |=> (mask_q == ($past(mask_q) | $past(wdata)))); // R4
  AST_EN_CLR_AND: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDXW'(3)) |=> (mask_q == ($past(mask_q) & ~$past(wdata)))); // R5
  AST_RT_SET_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDXW'(8)) |=> (rt_q == ($past(rt_q) | ($past(wdata) & RT_WIN)))); // R7
  AST_SOFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (idx == IDXW'(4) || idx == IDXW'(5)) && wdata == '0) |=> $stable(mask_q)); // R9
  AST_UNLISTED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(idx inside {IDXW'(2), IDXW'(3), IDXW'(4), IDXW'(5), IDXW'(8), IDXW'(9)}))
    |=> ($stable(mask_q) && $stable(rt_q))); // R10
endmodule

// File: rtl/sic_combine.sv
module sic_combine #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] mask_nx,
  output logic            irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(src_i & mask_nx);
  end

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_nx == '0) |=> !irq_o); // R6
endmodule

// File: rtl/sic_bypass.sv
module sic_bypass #(
  parameter int NSRC  = 32,
  parameter int RT_LO = 21,
  parameter int RT_HI = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] rt_nx,
  output logic [NSRC-1:0] route_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_line
    if (i >= RT_LO && i <= RT_HI) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) route_o[i] <= 1'b0;
        else        route_o[i] <= src_i[i] & rt_nx[i];
      end
    end else begin : g_tied
      assign route_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sic_route_top.sv
module sic_route_top #(
  parameter int NSRC  = 32,
  parameter int AW    = 12,
  parameter int RT_LO = 21,
  parameter int RT_HI = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  input  logic [NSRC-1:0] src_i,
  output logic            irq_o,
  output logic [NSRC-1:0] route_o
);
  localparam int IDXW = AW - 2;

  logic [NSRC-1:0] raw_q, mask_q, mask_nx, rt_q, rt_nx;
  logic [IDXW-1:0] idx;

  assign idx = bus_addr[AW-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= src_i;
  end

  sic_regfile #(.NSRC(NSRC), .IDXW(IDXW), .RT_LO(RT_LO), .RT_HI(RT_HI)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_sel & bus_wr), .rd_en(bus_sel & ~bus_wr),
    .idx(idx), .wdata(bus_wdata), .raw_q(raw_q),
    .mask_q(mask_q), .mask_nx(mask_nx), .rt_q(rt_q), .rt_nx(rt_nx),
    .rdata(bus_rdata)
  );

  sic_combine #(.NSRC(NSRC)) u_comb (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .mask_nx(mask_nx), .irq_o(irq_o)
  );

  sic_bypass #(.NSRC(NSRC), .RT_LO(RT_LO), .RT_HI(RT_HI)) u_byp (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rt_nx(rt_nx), .route_o(route_o)
  );

  AST_IRQ_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(raw_q & mask_q)); // R6
  AST_ROUTE_FOLLOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    route_o == (raw_q & rt_q)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!irq_o && route_o == '0)); // R1
endmodule

// File: tb/test_sic_route_top.sv
module test_sic_route_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, src_i = '0, route_o;
  logic        irq_o;

  int total = 0, bad = 0;
  logic [31:0] m_raw = '0, m_mask = '0, m_rt = '0;
  localparam logic [31:0] WIN = 32'h7FE0_0000;

  always #2 clk = ~clk;

  sic_route_top i_sic_route_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_i(src_i), .irq_o(irq_o), .route_o(route_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int i);
    case (i)
      0: return m_raw & m_mask;
      1: return m_raw;
      2: return m_mask;
      4: return {31'b0, m_raw[0]};
      8: return m_rt;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(int i, logic [31:0] d);
    case (i)
      2: m_mask = m_mask | d;
      3: m_mask = m_mask & ~d;
      4: if (d != 0) m_mask[0] = 1'b1;
      5: if (d != 0) m_mask[0] = 1'b0;
      8: m_rt = m_rt | (d & WIN);
      9: m_rt = m_rt & ~d;
      default: ;
    endcase
  endfunction

  // one cycle: drive at negedge, model at posedge, check outputs at next negedge
  task automatic cycle(bit do_wr, logic [11:0] addr, logic [31:0] d, logic [31:0] s);
    @(negedge clk);
    bus_sel = do_wr; bus_wr = do_wr; bus_addr = addr; bus_wdata = d; src_i = s;
    @(posedge clk);
    m_raw = s;
    if (do_wr) model_write(int'(addr[11:2]), d);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R6 irq_o", {31'b0, irq_o}, {31'b0, |(m_raw & m_mask)});
    chk("R8 route_o", route_o, m_raw & m_rt);
  endtask

  task automatic rd(string req, logic [11:0] addr);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
    #1;
    chk(req, bus_rdata, exp_read(int'(addr[11:2])));
    bus_sel = 1'b0;
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 irq_o reset", {31'b0, irq_o}, 32'h0);
    chk("R1 route_o reset", route_o, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 mask reset", 12'h008);
    rd("R1 route enable reset", 12'h020);

    cycle(0, 12'h0, 0, 32'hFFFF_FFFF);
    chk("R6 no mask no irq", {31'b0, irq_o}, 32'h0);
    rd("R2 raw read", 12'h004);
    cycle(1, 12'h008, 32'h0000_F0F0, 32'h0000_1000);
    rd("R4 enable set", 12'h008);
    rd("R3 status", 12'h000);
    cycle(1, 12'h00C, 32'h0000_3030, 32'h0000_1000);
    rd("R5 enable clear", 12'h008);
    cycle(1, 12'h020, 32'hFFFF_FFFF, 32'h0200_0000);
    rd("R7 route set window only", 12'h020);
    chk("R8 mask-free route bit25", route_o, 32'h0200_0000);
    cycle(1, 12'h024, 32'h0200_0000, 32'h0200_0000);
    rd("R7 route clear", 12'h020);
    chk("R8 disabled line low", route_o, 32'h0);
    cycle(1, 12'h010, 32'h0, 32'h1);
    rd("R9 zero soft set ignored", 12'h008);
    cycle(1, 12'h010, 32'h4, 32'h1);
    rd("R9 soft set", 12'h008);
    rd("R9 soft read", 12'h010);
    cycle(1, 12'h014, 32'h0, 32'h1);
    rd("R9 zero soft clear ignored", 12'h008);
    cycle(1, 12'h014, 32'h1, 32'h1);
    rd("R9 soft clear", 12'h008);
    cycle(1, 12'h018, 32'hFFFF_FFFF, 32'h1);
    cycle(1, 12'hFFC, 32'hFFFF_FFFF, 32'h1);
    rd("R10 unlisted write mask", 12'h008);
    rd("R10 unlisted write route", 12'h020);
    rd("R10 read index 3", 12'h00C);
    rd("R10 read index 9", 12'h024);
    rd("R10 read high index", 12'h7F0);
    rd("R10 low bits ignored", 12'h00B);

    for (int n = 0; n < 400; n++) begin
      int pick = int'($urandom_range(0, 9));
      logic [11:0] a;
      logic [31:0] d = ($urandom_range(0, 4) == 0) ? 32'h0 : $urandom();
      case (pick)
        0, 1: a = 12'h020;
        2:    a = 12'h024;
        3:    a = 12'h00C;
        4:    a = 12'h008;
        5:    a = {$urandom_range(0, 1) == 1 ? 8'h00 : 8'(3'($urandom())), 2'b0, 2'($urandom())} ;
        default: a = 12'($urandom_range(0, 11) << 2) | 12'($urandom_range(0, 3));
      endcase
      cycle($urandom_range(0, 3) != 0, a, d, $urandom());
      rd("R3 random read", 12'($urandom_range(0, 10) << 2));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule